// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits next to an instruction fetch unit and repeats a contiguous run of instructions with no branch instruction in the loop body. A loop-setup instruction raises a strobe while its own fetch address is on the program counter input. In that cycle the block records three values. The start address is the address that follows the setup instruction. The end address is the last instruction of the body. The remaining count comes from a 14-bit immediate or from the low 14 bits of a general register.

From then on the block compares every fetch address with the stored end address. When the fetch reaches the end address and passes remain, the block raises a redirect flag in that same cycle and gives the start address as the next fetch target, so no bubble is added. The instruction at the end address still executes on every pass. A programmed count of n runs the body n+1 times. After the last pass, fetch falls through past the end address and the block goes inactive.

Three states make up the controller. `LP_IDLE` means no loop is active. `LP_REPEAT` means passes remain. `LP_FINAL` means the current pass is the last one. The transitions are:
- *arm* goes from any state to `LP_REPEAT` on setup with a non-zero count.
- *arm-once* goes from any state to `LP_FINAL` on setup with a zero count.
- *wrap* keeps `LP_REPEAT` at an end match when more than one pass remains.
- *last-wrap* goes from `LP_REPEAT` to `LP_FINAL` at an end match with exactly one pass left.
- *exit* goes from `LP_FINAL` to `LP_IDLE` at an end match.
- *hold* keeps the current state in every other cycle.

Top module: `hwloop_ctrl`

## Requirements
- R1: While reset is held, and after reset until the first setup, `active_o` is 0 and `redirect_o` is 0 for any `pc_i`.
- R2: On a setup cycle the start address is captured as `pc_i + 2`. From the next cycle `redirect_pc_o` shows that address.
- R3: When `cnt_from_reg_i` = 0 the count is `cnt_imm_i`. When it is 1 the count is bits [13:0] of `gpr_val_i`, and bits [31:14] have no effect.
- R4: With count n, `redirect_o` is raised exactly n times before the loop exits, so the body runs n+1 times.
- R5: `redirect_o` is raised combinationally in the same cycle that `pc_i` equals the stored end address while passes remain. In that cycle `redirect_pc_o` equals the start address.
- R6: With count 0 the end match raises no redirect. `active_o` falls in the cycle after the final end match.
- R7: Fetch addresses other than the end address raise no redirect and do not consume a pass.
- R8: A setup while a loop is active replaces the start address, the end address and the count. The old end address stops triggering.
- R9: In a setup cycle `redirect_o` is 0, even when `pc_i` equals the old end address.
- R10: `active_o` is 1 from the cycle after setup until the cycle after the final end match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| setup_i | input | 1 | Loop-setup strobe; `pc_i` holds the setup instruction address |
| cnt_from_reg_i | input | 1 | Count source: 0 = immediate, 1 = register |
| cnt_imm_i | input | 14 | Immediate iteration count |
| gpr_val_i | input | 32 | General register value; the low 14 bits give the count |
| loop_end_i | input | 16 | Address of the last body instruction |
| pc_i | input | 16 | Current fetch address |
| redirect_o | output | 1 | Next fetch must go to `redirect_pc_o` |
| redirect_pc_o | output | 16 | Loop start address |
| active_o | output | 1 | A loop is armed |

## Verification
The redirect flag and its target are combinational on `pc_i`, so they are due in the same cycle the address is presented. The bench drives the inputs on the falling edge and reads these outputs one time unit later, in the same half cycle. The captured start address and `active_o` come from registers and are due one rising edge after the setup or final end match. The bench reads them after that edge and before it changes the inputs again. A fetch walker follows the actual redirect flag, counts the passes and compares the count with n+1, which it computes from the selected count source.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

    // Loop controller states
    typedef enum logic [1:0] {
        LP_IDLE   = 2'd0,  // no loop armed
        LP_REPEAT = 2'd1,  // at least one more wrap pending
        LP_FINAL  = 2'd2   // current pass is the last one
    } lp_state_e;

endpackage

// File: rtl/hwloop_count_src.sv
module hwloop_count_src #(
    parameter int CNT_W = 14,
    parameter int GPR_W = 32
) (
    input  logic             use_reg_i,
    input  logic [CNT_W-1:0] imm_i,
    input  logic [GPR_W-1:0] gpr_i,
    output logic [CNT_W-1:0] cnt_o
);

    // Only the low CNT_W register bits form the count.
    always_comb begin
        cnt_o = use_reg_i ? gpr_i[CNT_W-1:0] : imm_i;
    end

    generate
        if (GPR_W > CNT_W) begin : g_hi_drop
            logic unused_hi_bits;
            assign unused_hi_bits = ^gpr_i[GPR_W-1:CNT_W];
        end
    endgenerate

endmodule

// File: rtl/hwloop_regs.sv
module hwloop_regs #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 14,
    parameter int STEP   = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic              dec_i,
    input  logic [ADDR_W-1:0] setup_pc_i,
    input  logic [ADDR_W-1:0] end_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [ADDR_W-1:0] start_o,
    output logic [ADDR_W-1:0] end_o,
    output logic [CNT_W-1:0]  remain_o
);

    localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);
    localparam logic [CNT_W-1:0]  ONE_C  = CNT_W'(1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            start_o  <= '0;
            end_o    <= '0;
            remain_o <= '0;
        end else if (load_i) begin
            start_o  <= setup_pc_i + STEP_A;
            end_o    <= end_i;
            remain_o <= cnt_i;
        end else if (dec_i) begin
            remain_o <= remain_o - ONE_C;
        end
    end

endmodule

// File: rtl/hwloop_fsm.sv
module hwloop_fsm
    import hwloop_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic setup_i,
    input  logic load_zero_i,   // count being loaded is zero
    input  logic match_i,       // fetch address equals stored end address
    input  logic remain_one_i,  // exactly one wrap left
    output logic redirect_o,
    output logic dec_o,
    output logic active_o
);

    lp_state_e state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (setup_i) begin
            state_d = load_zero_i ? LP_FINAL : LP_REPEAT;   // arm-once / arm
        end else begin
            unique case (state_q)
                LP_IDLE:   state_d = LP_IDLE;
                LP_REPEAT: if (match_i) state_d = remain_one_i ? LP_FINAL : LP_REPEAT;
                LP_FINAL:  if (match_i) state_d = LP_IDLE;  // exit
                default:   state_d = LP_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= LP_IDLE;
        else         state_q <= state_d;
    end

    // Outputs
    always_comb begin
        redirect_o = 1'b0;
        dec_o      = 1'b0;
        active_o   = 1'b0;
        unique case (state_q)
            LP_IDLE: begin
                active_o = 1'b0;
            end
            LP_REPEAT: begin
                active_o   = 1'b1;
                redirect_o = match_i && !setup_i;
                dec_o      = match_i && !setup_i;
            end
            LP_FINAL: begin
                active_o = 1'b1;
            end
            default: begin
                active_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 14,
    parameter int GPR_W  = 32,
    parameter int STEP   = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              setup_i,
    input  logic              cnt_from_reg_i,
    input  logic [CNT_W-1:0]  cnt_imm_i,
    input  logic [GPR_W-1:0]  gpr_val_i,
    input  logic [ADDR_W-1:0] loop_end_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic              redirect_o,
    output logic [ADDR_W-1:0] redirect_pc_o,
    output logic              active_o
);

    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    logic [CNT_W-1:0]  new_cnt;
    logic [ADDR_W-1:0] start_q;
    logic [ADDR_W-1:0] end_q;
    logic [CNT_W-1:0]  remain_q;
    logic              pc_match;
    logic              dec;

    hwloop_count_src #(.CNT_W(CNT_W), .GPR_W(GPR_W)) u_cnt (
        .use_reg_i (cnt_from_reg_i),
        .imm_i     (cnt_imm_i),
        .gpr_i     (gpr_val_i),
        .cnt_o     (new_cnt)
    );

    hwloop_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP(STEP)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (setup_i),
        .dec_i      (dec),
        .setup_pc_i (pc_i),
        .end_i      (loop_end_i),
        .cnt_i      (new_cnt),
        .start_o    (start_q),
        .end_o      (end_q),
        .remain_o   (remain_q)
    );

    assign pc_match = (pc_i == end_q);

    hwloop_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .setup_i      (setup_i),
        .load_zero_i  (new_cnt == '0),
        .match_i      (pc_match),
        .remain_one_i (remain_q == ONE_C),
        .redirect_o   (redirect_o),
        .dec_o        (dec),
        .active_o     (active_o)
    );

    assign redirect_pc_o = start_q;

endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int STEP   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              setup_i,
    input logic [ADDR_W-1:0] pc_i,
    input logic              redirect_o,
    input logic [ADDR_W-1:0] redirect_pc_o,
    input logic              active_o,
    input logic [ADDR_W-1:0] end_q
);

    localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> !redirect_o);

    assert_start_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        setup_i |=> (redirect_pc_o == $past(pc_i) + STEP_A));

    assert_match_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (pc_i == end_q));

    assert_final_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !setup_i && (pc_i == end_q) && !redirect_o) |=> !active_o);

    assert_off_end_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !setup_i && (pc_i != end_q)) |=> (active_o && $stable(redirect_pc_o)));

    assert_setup_no_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        setup_i |-> !redirect_o);

    assert_setup_arms_R10: assert property (@(posedge clk) disable iff (!rst_n)
        setup_i |=> active_o);

endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.ADDR_W(ADDR_W), .STEP(STEP)) u_chk (
    .clk           (clk_i),
    .rst_n         (rst_ni),
    .setup_i       (setup_i),
    .pc_i          (pc_i),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .active_o      (active_o),
    .end_q         (end_q)
);

// File: tb/hwloop_ctrl_test.sv
module hwloop_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        setup_i = 1'b0;
    logic        cnt_from_reg_i = 1'b0;
    logic [13:0] cnt_imm_i = '0;
    logic [31:0] gpr_val_i = '0;
    logic [15:0] loop_end_i = '0;
    logic [15:0] pc_i = '0;
    logic        redirect_o;
    logic [15:0] redirect_pc_o;
    logic        active_o;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hwloop_ctrl uut (
        .clk_i(clk), .rst_ni(rst_n), .setup_i(setup_i),
        .cnt_from_reg_i(cnt_from_reg_i), .cnt_imm_i(cnt_imm_i),
        .gpr_val_i(gpr_val_i), .loop_end_i(loop_end_i), .pc_i(pc_i),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o), .active_o(active_o)
    );

    // Vector table: source select, immediate, register, setup pc, end address
    localparam int NV = 6;
    localparam logic        V_SEL [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic [13:0] V_IMM [NV] = '{14'd3, 14'd0, 14'd9, 14'd7, 14'd16383, 14'd0};
    localparam logic [31:0] V_GPR [NV] = '{32'd0, 32'd5, 32'hFFFF_C002, 32'h0000_4001, 32'd4, 32'h0001_0000};
    localparam logic [15:0] V_PC  [NV] = '{16'h0100, 16'h0200, 16'h0300, 16'h0400, 16'h0500, 16'h0600};
    localparam logic [15:0] V_END [NV] = '{16'h0108, 16'h0204, 16'h0302, 16'h0410, 16'h0502, 16'h0606};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    task automatic do_setup(input logic sel, input logic [13:0] imm, input logic [31:0] gpr,
                            input logic [15:0] spc, input logic [15:0] ea);
        @(negedge clk);
        setup_i = 1'b1; cnt_from_reg_i = sel; cnt_imm_i = imm;
        gpr_val_i = gpr; pc_i = spc; loop_end_i = ea;
        #1;
        check(!redirect_o, "R9 setup cycle redirect", int'(redirect_o), 0);
        @(posedge clk);
        #1;
        check(active_o, "R10 active after setup", int'(active_o), 1);
        check(redirect_pc_o == spc + 16'd2, "R2 start address", int'(redirect_pc_o), int'(spc + 16'd2));
    endtask

    // Fetch walker following the actual redirect flag
    task automatic walk(input logic [15:0] s, input logic [15:0] e, output int reds, output int bad);
        logic [15:0] pc;
        pc = s; reds = 0; bad = 0;
        for (int g = 0; g < 60000; g++) begin
            @(negedge clk);
            setup_i = 1'b0; pc_i = pc;
            #1;
            if (!active_o) bad++;
            if (redirect_o && (redirect_pc_o != s)) bad++;
            if (redirect_o && (pc != e)) bad++;
            if (pc == e) begin
                if (redirect_o) begin reds++; pc = s; end
                else break;
            end else begin
                pc = pc + 16'd2;
            end
        end
        @(negedge clk);
        pc_i = e + 16'd2;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        int reds, bad, n;
        // R1: reset state
        pc_i = 16'h0000;
        #(CLK_PERIOD * 2 + 1);
        check(!active_o && !redirect_o, "R1 in reset", int'({active_o, redirect_o}), 0);
        @(negedge clk); rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); pc_i = 16'(k * 2); #1;
            check(!active_o && !redirect_o, "R1 idle after reset", int'({active_o, redirect_o}), 0);
        end

        // Vector table: R3 source select, R4 pass count, R5 in-cycle redirect, R6/R10 exit
        for (int v = 0; v < NV; v++) begin
            n = V_SEL[v] ? int'(V_GPR[v][13:0]) : int'(V_IMM[v]);
            do_setup(V_SEL[v], V_IMM[v], V_GPR[v], V_PC[v], V_END[v]);
            walk(V_PC[v] + 16'd2, V_END[v], reds, bad);
            check(reds == n, "R3 R4 redirect count", reds, n);
            check(bad == 0, "R5 R10 in-loop misbehaviour", bad, 0);
            check(!active_o, "R6 R10 inactive after final pass", int'(active_o), 0);
            check(!redirect_o, "R6 no redirect after exit", int'(redirect_o), 0);
        end

        // R7: excursion to other addresses consumes nothing
        do_setup(1'b0, 14'd2, 32'd0, 16'h0700, 16'h0706);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); setup_i = 1'b0; pc_i = 16'h0900 + 16'(k * 2); #1;
            check(!redirect_o && active_o, "R7 off-end address", int'({active_o, redirect_o}), 2);
        end
        walk(16'h0702, 16'h0706, reds, bad);
        check(reds == 2 && bad == 0, "R7 count kept", reds, 2);

        // R8: overwrite while active
        do_setup(1'b0, 14'd5, 32'd0, 16'h0800, 16'h0804);
        @(negedge clk); setup_i = 1'b0; pc_i = 16'h0804; #1;
        check(redirect_o, "R8 first loop wraps", int'(redirect_o), 1);
        do_setup(1'b0, 14'd1, 32'd0, 16'h0A00, 16'h0A06);
        @(negedge clk); setup_i = 1'b0; pc_i = 16'h0804; #1;
        check(!redirect_o, "R8 old end ignored", int'(redirect_o), 0);
        walk(16'h0A02, 16'h0A06, reds, bad);
        check(reds == 1 && bad == 0, "R8 new count", reds, 1);
        check(!active_o, "R8 exit after new loop", int'(active_o), 0);

        // R9: setup on the old end address suppresses redirect
        do_setup(1'b0, 14'd3, 32'd0, 16'h0B00, 16'h0B04);
        @(negedge clk);
        setup_i = 1'b1; pc_i = 16'h0B04; cnt_imm_i = 14'd0; loop_end_i = 16'h0B10;
        #1;
        check(!redirect_o, "R9 setup at old end", int'(redirect_o), 0);
        @(posedge clk); #1;
        check(redirect_pc_o == 16'h0B06, "R9 R2 reloaded start", int'(redirect_pc_o), 16'h0B06);
        walk(16'h0B06, 16'h0B10, reds, bad);
        check(reds == 0 && bad == 0, "R9 R6 zero-count reload", reds, 0);

        // R1: reset mid-loop clears activity
        do_setup(1'b0, 14'd4, 32'd0, 16'h0C00, 16'h0C02);
        @(negedge clk); setup_i = 1'b0; rst_n = 1'b0; pc_i = 16'h0C02; #1;
        check(!active_o && !redirect_o, "R1 reset mid-loop", int'({active_o, redirect_o}), 0);

        report();
        $finish;
    end

endmodule